// File: doc/BRIEF.md
# Keyed Erase Controller for a Small Data Nonvolatile Array

This block guards erase operations on a small data nonvolatile array behind a register bus. Software first loads the target word address and an erase mode into registers. It then writes a two-value unlock key to a dedicated key register and, within a short window, writes the control register with its start bit set. Only that exact ordered handshake lets an erase begin. Any stray register write breaks the handshake, and so do a wrong key, a late start or a missing write enable. In each of those cases no erase takes place and a sticky error bit is raised.

An accepted erase drives an array-side strobe for a timed interval, either on one word or on a whole row. The interval is a parameter given as a clock rate and a duration in microseconds. The block never stalls the bus during an erase. Software learns that the erase is over in one of two ways: it can poll the start bit, which the hardware clears, or it can take the sticky completion interrupt, which stays set until software writes it back to zero.

Register map (bus word offsets): 0 control, 1 key, 2 target address, 3 completion flag. Control bits: 15 start/busy, 14 write enable, 13 error, 6 erase select, 3:0 operation code (4 = single word, 5 = whole row).

Top module: `nvm_erase_ctrl`

## Requirements
- R1: After reset, the control register (offset 0) and the flag register (offset 3) read 0, and `irq` and `ers_active` are low.
- R2: Writing 0x0055 and then 0x00AA to the key register (offset 1), followed by a control write with bit 15 = 1, bit 14 = 1, bit 6 = 1 and opcode 4 or 5, starts an erase. Control bit 15 then reads 1.
- R3: Any bus write that lands between the key writes, or between the second key and the start write, cancels the unlock. A start write that follows finds no valid unlock: no erase begins, and control bit 13 (error) is set.
- R4: The keys are accepted only as 0x0055 followed by 0x00AA. The reverse order does not unlock, and a start write that follows finds no valid unlock, with the same result as in R3.
- R5: The start write must reach the bus no more than KEY_WIN clock cycles after the 0x0055 write. With the default of 5, a start at distance 5 is accepted and a start at distance 6 is not.
- R6: A start write that has the unlock but has bit 14 clear, bit 6 clear or an opcode other than 4 or 5 is ignored, and error bit 13 is set. A control write with bit 13 = 0 clears the error bit.
- R7: Opcode 5 erases a row: `ers_row` = 1 and `ers_addr` is the target address rounded down to a multiple of ROW_WORDS. Opcode 4 erases one word: `ers_row` = 0 and `ers_addr` is the exact target address.
- R8: `ers_active` and control bit 15 stay high for exactly (CLK_HZ/1000)*ERASE_US/1000 cycles, after which the hardware clears both.
- R9: When an erase ends, flag bit 0 (offset 3) and `irq` become 1. They remain set until software writes 0 to flag bit 0; writing 1 has no effect.
- R10: While an erase is running, writes to the control and address registers are ignored. Their read values and `ers_addr` / `ers_row` stay unchanged.
- R11: An unlock is good for a single start attempt. A second start write with no new key sequence does not erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | BUS_AW | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| ers_active | output | 1 | Erase strobe, high for the whole erase interval |
| ers_row | output | 1 | 1 for row erase, 0 for word erase |
| ers_addr | output | ADDR_W | Word or row-aligned address being erased |
| irq | output | 1 | Sticky erase-complete interrupt |

## Verification
The hardest case to reach from the ports is the edge of the unlock window. Here a fully correct key sequence is either just inside or just past KEY_WIN cycles, so the outcome depends only on cycle distance. The stimulus places the two key writes on consecutive edges and then inserts an exact number of idle cycles before the start write: three idle cycles to land at the limit, four to fall one cycle past it. Interruptions of the sequence by an unrelated write are built the same way, with the stray write placed between the two keys. Write attempts made in the middle of a running erase are issued while the strobe is held, and their effect is read back through the bus before the erase ends.

// File: rtl/nvm_erase_pkg.sv
package nvm_erase_pkg;

    localparam int unsigned DW = 16;

    // register word offsets
    localparam int unsigned REG_CTRL = 0;
    localparam int unsigned REG_KEY  = 1;
    localparam int unsigned REG_ADDR = 2;
    localparam int unsigned REG_FLAG = 3;

    // control bit positions
    localparam int unsigned CB_START = 15;
    localparam int unsigned CB_WREN  = 14;
    localparam int unsigned CB_ERR   = 13;
    localparam int unsigned CB_ERASE = 6;

    localparam logic [3:0] OP_WORD = 4'h4;
    localparam logic [3:0] OP_ROW  = 4'h5;

    localparam logic [DW-1:0] KEY_FIRST  = 16'h0055;
    localparam logic [DW-1:0] KEY_SECOND = 16'h00AA;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_HALF = 2'd1,
        KS_OPEN = 2'd2
    } key_state_t;

    typedef struct packed {
        logic       wren;
        logic       err;
        logic       erase;
        logic [3:0] op;
    } ctrl_t;

    function automatic logic mode_valid(input logic [DW-1:0] w);
        return w[CB_WREN] && w[CB_ERASE] &&
               ((w[3:0] == OP_WORD) || (w[3:0] == OP_ROW));
    endfunction

    function automatic logic [DW-1:0] pack_ctrl(input logic busy, input ctrl_t c);
        logic [DW-1:0] r;
        r           = '0;
        r[CB_START] = busy;
        r[CB_WREN]  = c.wren;
        r[CB_ERR]   = c.err;
        r[CB_ERASE] = c.erase;
        r[3:0]      = c.op;
        return r;
    endfunction

endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
    import nvm_erase_pkg::*;
#(
    parameter int unsigned KEY_WIN = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          any_wr,
    input  logic          key_wr,
    input  logic [DW-1:0] wdata,
    output logic          unlocked
);
    localparam int unsigned WIN_W = $clog2(KEY_WIN + 1) + 1;

    key_state_t       state_q, state_d;
    logic [WIN_W-1:0] win_q, win_d;

    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        if (state_q == KS_IDLE) begin
            if (key_wr && wdata == KEY_FIRST) begin
                state_d = KS_HALF;
                win_d   = WIN_W'(1);
            end
        end else begin
            if (any_wr) begin
                if (state_q == KS_HALF && key_wr && wdata == KEY_SECOND)
                    state_d = KS_OPEN;
                else
                    state_d = KS_IDLE;
            end
            win_d = win_q + WIN_W'(1);
            if (win_q >= WIN_W'(KEY_WIN))
                state_d = KS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_IDLE;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
        end
    end

    assign unlocked = (state_q == KS_OPEN);

endmodule

// File: rtl/nvm_erase_timer.sv
module nvm_erase_timer #(
    parameter int unsigned CYC = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    assign done = busy_q && (cnt_q == '0);
    assign busy = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= CW'(CYC - 1);
            end
        end else if (done) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

endmodule

// File: rtl/nvm_erase_ctrl.sv
module nvm_erase_ctrl
    import nvm_erase_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned ERASE_US  = 2000,
    parameter int unsigned KEY_WIN   = 5,
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned ROW_WORDS = 32,
    parameter int unsigned BUS_AW    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we,
    output logic [DW-1:0]     bus_rdata,
    output logic              ers_active,
    output logic              ers_row,
    output logic [ADDR_W-1:0] ers_addr,
    output logic              irq
);
    localparam int unsigned ERASE_CYC = (CLK_HZ / 1000) * ERASE_US / 1000;
    localparam logic [ADDR_W-1:0] ROW_MASK = ~(ADDR_W'(ROW_WORDS - 1));

    logic sel_ctrl, sel_key, sel_addr, sel_flag;
    assign sel_ctrl = (bus_addr == BUS_AW'(REG_CTRL));
    assign sel_key  = (bus_addr == BUS_AW'(REG_KEY));
    assign sel_addr = (bus_addr == BUS_AW'(REG_ADDR));
    assign sel_flag = (bus_addr == BUS_AW'(REG_FLAG));

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] tgt_q;
    logic              flag_q;
    logic              row_q;
    logic [ADDR_W-1:0] ers_addr_q;

    logic busy, done, unlocked;
    logic ctrl_wr, start_req, start_ok, err_set;

    nvm_key_seq #(.KEY_WIN(KEY_WIN)) u_keys (
        .clk      (clk),
        .rst      (rst),
        .any_wr   (bus_we),
        .key_wr   (bus_we && sel_key),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    nvm_erase_timer #(.CYC(ERASE_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start_ok),
        .busy  (busy),
        .done  (done)
    );

    assign ctrl_wr   = bus_we && sel_ctrl && !busy;
    assign start_req = ctrl_wr && bus_wdata[CB_START];
    assign start_ok  = start_req && unlocked && mode_valid(bus_wdata);
    assign err_set   = start_req && !start_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.wren  <= bus_wdata[CB_WREN];
            ctrl_q.erase <= bus_wdata[CB_ERASE];
            ctrl_q.op    <= bus_wdata[3:0];
            ctrl_q.err   <= err_set || (ctrl_q.err && bus_wdata[CB_ERR]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            tgt_q <= '0;
        else if (bus_we && sel_addr && !busy)
            tgt_q <= bus_wdata[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q      <= 1'b0;
            ers_addr_q <= '0;
        end else if (start_ok) begin
            row_q      <= (bus_wdata[3:0] == OP_ROW);
            ers_addr_q <= (bus_wdata[3:0] == OP_ROW) ? (tgt_q & ROW_MASK) : tgt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (done)
            flag_q <= 1'b1;
        else if (bus_we && sel_flag && !bus_wdata[0])
            flag_q <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)
            bus_rdata = pack_ctrl(busy, ctrl_q);
        else if (sel_addr)
            bus_rdata = DW'(tgt_q);
        else if (sel_flag)
            bus_rdata = DW'(flag_q);
    end

    assign ers_active = busy;
    assign ers_row    = row_q;
    assign ers_addr   = ers_addr_q;
    assign irq        = flag_q;

endmodule

// File: rtl/nvm_erase_chk.sv
module nvm_erase_chk #(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned ERASE_US  = 2000,
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned ROW_WORDS = 32,
    parameter int unsigned BUS_AW    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_we,
    input logic [15:0]       bus_rdata,
    input logic              ers_active,
    input logic              ers_row,
    input logic [ADDR_W-1:0] ers_addr,
    input logic              irq
);
    localparam int unsigned ERASE_CYC = (CLK_HZ / 1000) * ERASE_US / 1000;

    logic [31:0] act_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            act_cnt <= '0;
        else
            act_cnt <= ers_active ? act_cnt + 32'd1 : 32'd0;
    end

    p_start_write_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ers_active) |-> $past(bus_we && bus_addr == BUS_AW'(0) && bus_wdata[15]));

    p_length_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(ers_active) |-> act_cnt == ERASE_CYC);

    p_busy_visible_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == BUS_AW'(0)) |-> bus_rdata[15] == ers_active);

    p_target_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (ers_active && $past(ers_active)) |-> ($stable(ers_addr) && $stable(ers_row)));

    p_row_align_r7: assert property (@(posedge clk) disable iff (rst)
        (ers_active && ers_row) |-> (ers_addr & ADDR_W'(ROW_WORDS - 1)) == '0);

    p_irq_on_end_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(ers_active) |-> irq);

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !(bus_we && bus_addr == BUS_AW'(3) && !bus_wdata[0])) |=> irq);

endmodule

bind nvm_erase_ctrl nvm_erase_chk #(
    .CLK_HZ(CLK_HZ), .ERASE_US(ERASE_US), .ADDR_W(ADDR_W),
    .ROW_WORDS(ROW_WORDS), .BUS_AW(BUS_AW)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .ers_active(ers_active),
    .ers_row(ers_row), .ers_addr(ers_addr), .irq(irq)
);

// File: tb/tb_nvm_erase_ctrl.sv
module tb_nvm_erase_ctrl;
    localparam int unsigned CYC = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic        ers_active, ers_row, irq;
    logic [9:0]  ers_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nvm_erase_ctrl #(
        .CLK_HZ(1_000_000), .ERASE_US(50), .KEY_WIN(5),
        .ADDR_W(10), .ROW_WORDS(32), .BUS_AW(3)
    ) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .ers_active(ers_active),
        .ers_row(ers_row), .ers_addr(ers_addr), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic unlock();
        wr(3'd1, 16'h0055);
        wr(3'd1, 16'h00AA);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && ers_active; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(3'd0, d); chk("R1 ctrl", d, 16'h0000);
        rd(3'd3, d); chk("R1 flag", d, 16'h0000);
        chk("R1 irq", irq, 0);
        chk("R1 active", ers_active, 0);
    endtask

    task automatic t_word();
        logic [15:0] d;
        int n;
        wr(3'd2, 16'h0123);
        wr(3'd0, 16'h4044);
        unlock();
        wr(3'd0, 16'hC044);
        chk("R2 active", ers_active, 1);
        rd(3'd0, d); chk("R2 ctrl busy", d, 16'hC044);
        chk("R7 word row", ers_row, 0);
        chk("R7 word addr", ers_addr, 10'h123);
        n = 0;
        while (ers_active && n < 1000) begin n++; @(negedge clk); end
        chk("R8 length", n, CYC);
        rd(3'd0, d); chk("R8 cleared", d, 16'h4044);
        chk("R9 irq", irq, 1);
        rd(3'd3, d); chk("R9 flag", d, 16'h0001);
        wr(3'd3, 16'h0001);
        chk("R9 write1 keeps", irq, 1);
        wr(3'd3, 16'h0000);
        chk("R9 write0 clears", irq, 0);
        wr(3'd0, 16'hC044);
        chk("R11 no reuse", ers_active, 0);
        rd(3'd0, d); chk("R11 err", d, 16'h6044);
        wr(3'd0, 16'h4044);
        rd(3'd0, d); chk("R6 err clear", d, 16'h4044);
    endtask

    task automatic t_row();
        logic [15:0] d;
        wr(3'd2, 16'h02A7);
        wr(3'd0, 16'h4045);
        unlock();
        wr(3'd0, 16'hC045);
        chk("R7 row active", ers_active, 1);
        chk("R7 row flag", ers_row, 1);
        chk("R7 row addr", ers_addr, 10'h2A0);
        wr(3'd2, 16'h03FF);
        wr(3'd0, 16'h0000);
        rd(3'd2, d); chk("R10 addr kept", d, 16'h02A7);
        rd(3'd0, d); chk("R10 ctrl kept", d, 16'hC045);
        chk("R10 ers_addr kept", ers_addr, 10'h2A0);
        chk("R10 still active", ers_active, 1);
        wait_idle();
        wr(3'd3, 16'h0000);
    endtask

    task automatic t_break();
        logic [15:0] d;
        wr(3'd0, 16'h4044);
        wr(3'd1, 16'h0055);
        wr(3'd2, 16'h0010);
        wr(3'd1, 16'h00AA);
        wr(3'd0, 16'hC044);
        chk("R3 no erase", ers_active, 0);
        rd(3'd0, d); chk("R3 err", d, 16'h6044);
        wr(3'd0, 16'h4044);
        wr(3'd1, 16'h00AA);
        wr(3'd1, 16'h0055);
        wr(3'd0, 16'hC044);
        chk("R4 no erase", ers_active, 0);
        rd(3'd0, d); chk("R4 err", d, 16'h6044);
        wr(3'd0, 16'h4044);
    endtask

    task automatic t_window();
        unlock();
        repeat (4) @(negedge clk);
        wr(3'd0, 16'hC044);
        chk("R5 late start", ers_active, 0);
        wr(3'd0, 16'h4044);
        unlock();
        repeat (3) @(negedge clk);
        wr(3'd0, 16'hC044);
        chk("R5 start at limit", ers_active, 1);
        wait_idle();
        wr(3'd3, 16'h0000);
    endtask

    task automatic t_wren();
        logic [15:0] d;
        unlock();
        wr(3'd0, 16'h8044);
        chk("R6 no wren", ers_active, 0);
        rd(3'd0, d); chk("R6 err wren", d, 16'h2044);
        wr(3'd0, 16'h4044);
        unlock();
        wr(3'd0, 16'hC004);
        chk("R6 no erase bit", ers_active, 0);
        rd(3'd0, d); chk("R6 err mode", d, 16'h6004);
        wr(3'd0, 16'h4044);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_word();
        t_row();
        t_break();
        t_window();
        t_wren();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule